// File: doc/BRIEF.md
# Byte-Wide Flash Read Sequencer

This block turns one read request from a 32-bit internal bus into a short burst of 8-bit reads on an external flash or slow peripheral port. On that port the upper address bits and the returned data share the same eight pins. The sequencer first puts the upper address bits out over several one-cycle phases. In each phase it pulses one strobe of an address latch enable vector, so that an external latch can capture that slice of the address. It then drives the three low address bits directly and asserts chip enable and output enable together. It waits a programmed access delay, samples one byte and, when more bytes remain, waits a programmed recovery delay before the next byte.

The internal byte enables choose which bytes are read. The burst starts at the lowest enabled lane and moves up by one address for each byte. Each byte returned is placed on the 32-bit lane that matches its address, and lanes that are not selected read as zero. The requester receives one response beat per request, so it is disconnected after the first data phase. An empty byte-enable pattern completes at once with zero data. A pattern that is not contiguous also completes at once, with zero data and an error flag. The two delays are sampled when a request is accepted and held until that request is finished.

Top module: `flash_byte_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, fl_ce_n and fl_oe_n are 1, fl_ale is all zero, fl_ad_oe is 0 and rsp_valid is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the PHASES cycles that follow, cycle k (counting from 0) drives fl_ad_oe=1 and fl_ad_o = byte k of the zero-padded {req_addr[ADDR_W-1:3]}, least significant byte first. In that cycle fl_ale has only bit k set, and fl_ce_n and fl_oe_n are both 1.
- R3: Each byte access holds fl_ce_n=0 and fl_oe_n=0 with fl_ad_oe=0 for exactly cfg_acc+1 cycles. fl_ad_i is sampled on the clock edge that ends the last of these cycles, so a delay of 0 samples one cycle after the enables go active.
- R4: During the first access, fl_lo_addr equals {req_addr[2], index of the lowest set bit of req_be}. It rises by one for each later access.
- R5: A contiguous non-empty req_be produces exactly one access per set bit, in ascending lane order, with no other external activity.
- R6: After every access, including the last, fl_ce_n and fl_oe_n are 1 for exactly cfg_rec cycles before the next access or the response. With cfg_rec=0 the enables stay low from one access into the next.
- R7: In the response, the byte read with fl_lo_addr[1:0]=j appears on rsp_data[8j+7:8j], and every lane not selected by req_be is zero.
- R8: rsp_valid is 1 for exactly one cycle per request, in the cycle after the last recovery cycle. req_ready is 0 from the acceptance edge through the response cycle and is 1 in the cycle after it.
- R9: req_be=0 gives rsp_valid=1 in the cycle right after acceptance, with rsp_data=0, rsp_err=0 and no address or enable activity.
- R10: A non-contiguous req_be (5, 9, 10, 11 or 13) gives rsp_valid=1 in the cycle right after acceptance, with rsp_data=0, rsp_err=1 and no external activity. Every other response has rsp_err=0.
- R11: cfg_acc and cfg_rec are captured at acceptance. Changing them while a request is in progress has no effect on that request's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_acc | input | DLY_W | Access delay in cycles, from enables active to data sample |
| cfg_rec | input | DLY_W | Recovery delay in cycles, with enables inactive after each sample |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | ADDR_W-2 | Word address, bits ADDR_W-1 down to 2 |
| req_be | input | 4 | Byte enables of the requested word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected for a non-contiguous byte enable |
| rsp_data | output | 32 | Packed read data with unselected lanes zero |
| fl_ale | output | PHASES | Address latch strobes, one bit per upper-address slice |
| fl_ad_o | output | 8 | Shared pins, output value (address slices) |
| fl_ad_oe | output | 1 | Shared pins output enable |
| fl_ad_i | input | 8 | Shared pins, input value (returned data) |
| fl_lo_addr | output | 3 | Directly driven low address bits |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Time is counted in cycles after the acceptance edge. Address phase k is due in cycle k+1, and the first access window starts in cycle PHASES+1. With n bytes, the response is due in cycle PHASES + n*(cfg_acc+1+cfg_rec) + 1. An empty or rejected request answers in cycle 1, and req_ready comes back one cycle after the response. The bench builds this schedule from the request and the delays it applied, then steps one falling edge at a time and compares every pin against the cycle it expects. Its flash model returns valid data only once the enables have been held long enough, so a sample taken one cycle too early reads a poison byte.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACC,
    ST_REC,
    ST_RESP
  } fbr_state_e;
endpackage

// File: rtl/fbr_be_decode.sv
// Byte-enable analysis: lowest lane, number of lanes, contiguity.
module fbr_be_decode #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES),
  localparam int CW = LW + 1
) (
  input  logic [LANES-1:0] be,
  output logic [LW-1:0]    first,
  output logic [CW-1:0]    count,
  output logic             contig,
  output logic             empty
);
  logic             found;
  logic [LANES-1:0] shifted;
  logic [LANES:0]   ones;

  always_comb begin
    first = '0;
    count = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) begin
        count = count + CW'(1);
        if (!found) begin
          first = LW'(i);
          found = 1'b1;
        end
      end
    end
    shifted = be >> first;
    ones    = ({{LANES{1'b0}}, 1'b1} << count) - {{LANES{1'b0}}, 1'b1};
    contig  = ({1'b0, shifted} == ones);
    empty   = !found;
  end
endmodule

// File: rtl/fbr_delay_cnt.sv
// Loadable down counter; done while the count sits at zero.
module fbr_delay_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= val;
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/fbr_lane_pack.sv
// Word assembly: one byte register per lane, cleared per request.
module fbr_lane_pack #(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               we,
  input  logic [LW-1:0]      lane,
  input  logic [7:0]         din,
  output logic [LANES*8-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr)
        word[g*8 +: 8] <= 8'h00;
      else if (we && lane == LW'(g))
        word[g*8 +: 8] <= din;
    end
  end
endmodule

// File: rtl/flash_byte_rd_seq.sv
module flash_byte_rd_seq #(
  parameter int ADDR_W = 23,
  parameter int DLY_W  = 4,
  localparam int LANES  = 4,
  localparam int LW     = $clog2(LANES),
  localparam int CW     = LW + 1,
  localparam int LO_W   = 3,
  localparam int UP_W   = ADDR_W - LO_W,
  localparam int PHASES = (UP_W + 7) / 8,
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int PADW   = PHASES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DLY_W-1:0]   cfg_acc,
  input  logic [DLY_W-1:0]   cfg_rec,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:2]  req_addr,
  input  logic [LANES-1:0]   req_be,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [LANES*8-1:0] rsp_data,
  output logic [PHASES-1:0]  fl_ale,
  output logic [7:0]         fl_ad_o,
  output logic               fl_ad_oe,
  input  logic [7:0]         fl_ad_i,
  output logic [LO_W-1:0]    fl_lo_addr,
  output logic               fl_ce_n,
  output logic               fl_oe_n
);
  import fbr_pkg::*;

  fbr_state_e       st;
  logic [PH_W-1:0]  ph;
  logic [LO_W-1:0]  lo;
  logic [CW-1:0]    left;
  logic [DLY_W-1:0] acc_q, rec_q;
  logic [PADW-1:0]  up_q;
  logic             err_q;

  logic [LW-1:0]    be_first;
  logic [CW-1:0]    be_count;
  logic             be_contig, be_empty;
  logic             accept;
  logic             cnt_load, cnt_done;
  logic [DLY_W-1:0] cnt_val;
  logic             last_ph, take, load_acc, load_rec;

  fbr_be_decode #(.LANES(LANES)) u_dec (
    .be(req_be), .first(be_first), .count(be_count),
    .contig(be_contig), .empty(be_empty)
  );

  fbr_delay_cnt #(.W(DLY_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .val(cnt_val), .done(cnt_done)
  );

  fbr_lane_pack #(.LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .clr(accept), .we(take),
    .lane(lo[LW-1:0]), .din(fl_ad_i), .word(rsp_data)
  );

  assign accept  = req_valid && req_ready;
  assign last_ph = (ph == PH_W'(PHASES - 1));
  assign take    = (st == ST_ACC) && cnt_done;

  always_comb begin
    load_acc = ((st == ST_ADDR) && last_ph)
            || (take && left != '0 && rec_q == '0)
            || ((st == ST_REC) && cnt_done && left != '0);
    load_rec = take && rec_q != '0;
    cnt_load = load_acc || load_rec;
    cnt_val  = load_rec ? (rec_q - DLY_W'(1)) : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ph    <= '0;
      lo    <= '0;
      left  <= '0;
      acc_q <= '0;
      rec_q <= '0;
      up_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          acc_q <= cfg_acc;
          rec_q <= cfg_rec;
          up_q  <= PADW'(req_addr[ADDR_W-1:LO_W]);
          ph    <= '0;
          lo    <= {req_addr[2], be_first};
          left  <= be_count - CW'(1);
          if (be_empty || !be_contig) begin
            err_q <= !be_empty;
            st    <= ST_RESP;
          end else begin
            err_q <= 1'b0;
            st    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (last_ph) st <= ST_ACC;
          else         ph <= ph + PH_W'(1);
        end
        ST_ACC: if (cnt_done) begin
          if (rec_q != '0) begin
            st <= ST_REC;
          end else if (left == '0) begin
            st <= ST_RESP;
          end else begin
            lo   <= lo + LO_W'(1);
            left <= left - CW'(1);
          end
        end
        ST_REC: if (cnt_done) begin
          if (left == '0) begin
            st <= ST_RESP;
          end else begin
            st   <= ST_ACC;
            lo   <= lo + LO_W'(1);
            left <= left - CW'(1);
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Pin decode from registered state only: no input reaches an output.
  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_err    = err_q && (st == ST_RESP);
  assign fl_ce_n    = (st != ST_ACC);
  assign fl_oe_n    = (st != ST_ACC);
  assign fl_ad_oe   = (st == ST_ADDR);
  assign fl_ad_o    = up_q[{ph, 3'b000} +: 8];
  assign fl_lo_addr = lo;

  always_comb begin
    for (int k = 0; k < PHASES; k++)
      fl_ale[k] = (st == ST_ADDR) && (ph == PH_W'(k));
  end

  // Checks guarding the sequencing above.
  p_ale_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fl_ale));

  p_no_contention_r3: assert property (@(posedge clk) disable iff (rst)
    fl_ad_oe |-> (fl_oe_n && fl_ce_n));

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_empty_fast_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_be == '0) |=>
      (rsp_valid && !rsp_err && rsp_data == '0));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == '0 && fl_ce_n));
endmodule

// File: tb/flash_byte_rd_seq_test.sv
module flash_byte_rd_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_acc = 4'd2, cfg_rec = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:2] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [2:0]  fl_ale;
  logic [7:0]  fl_ad_o;
  logic        fl_ad_oe;
  logic [7:0]  fl_ad_i = 8'h00;
  logic [2:0]  fl_lo_addr;
  logic        fl_ce_n, fl_oe_n;

  int n_chk = 0, n_fail = 0;
  int lat = 2;
  bit done_flag = 0;

  always #2 clk = ~clk;

  flash_byte_rd_seq uut (
    .clk(clk), .rst(rst), .cfg_acc(cfg_acc), .cfg_rec(cfg_rec),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .fl_ale(fl_ale), .fl_ad_o(fl_ad_o),
    .fl_ad_oe(fl_ad_oe), .fl_ad_i(fl_ad_i), .fl_lo_addr(fl_lo_addr),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n)
  );

  function automatic logic [7:0] fbyte(input logic [22:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b1} ^ 8'h3C;
  endfunction

  // Flash model: external latch plus a byte source with access latency.
  logic [23:0] latch_up = '0;
  int          en_cnt = 0;
  logic [2:0]  prev_lo = '0;
  always @(negedge clk) begin
    for (int k = 0; k < 3; k++)
      if (fl_ale[k]) latch_up[k*8 +: 8] = fl_ad_o;
    if (!fl_ce_n && !fl_oe_n) begin
      if (en_cnt > 0 && fl_lo_addr == prev_lo) en_cnt = en_cnt + 1;
      else en_cnt = 1;
      prev_lo = fl_lo_addr;
      fl_ad_i <= (en_cnt >= lat + 1) ? fbyte({latch_up[19:0], fl_lo_addr}) : 8'hA5;
    end else begin
      en_cnt = 0;
      fl_ad_i <= 8'h00;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // status = {ready, ce_n, oe_n, ale[2:0], ad_oe, rsp_valid}
  function automatic logic [7:0] stat();
    return {req_ready, fl_ce_n, fl_oe_n, fl_ale, fl_ad_oe, rsp_valid};
  endfunction

  task automatic do_req(input logic [22:0] a, input logic [3:0] be,
                        input int acc, input int rec, input int lt, input bit mid);
    int n, first;
    bit contig;
    logic [31:0] exp_d;
    logic [23:0] pad;
    lat = lt;
    cfg_acc = 4'(acc);
    cfg_rec = 4'(rec);
    pad = {4'b0, a[22:3]};
    n = 0; first = 0;
    for (int i = 3; i >= 0; i--) if (be[i]) begin n++; first = i; end
    case (be)
      4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'h7, 4'hE, 4'hF, 4'h0: contig = 1;
      default: contig = 0;
    endcase
    exp_d = '0;
    for (int i = 0; i < 4; i++)
      if (be[i] && contig) exp_d[i*8 +: 8] = fbyte({a[22:2], 2'(i)});
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[22:2]; req_be = be;
    chk("R8 idle ready before accept", stat(), 8'b1110_0000);
    @(negedge clk);
    req_valid = 1'b0;
    if (mid) begin cfg_acc = 4'd7; cfg_rec = 4'd9; end
    if (n == 0 || !contig) begin
      chk(n == 0 ? "R9 empty response status" : "R10 reject response status",
          stat(), 8'b0110_0001);
      chk(n == 0 ? "R9 empty data/err" : "R10 reject data/err",
          {rsp_err, rsp_data}, {(n != 0), 32'h0});
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk("R2 address phase status", stat(), {3'b011, 3'(1 << k), 2'b10});
        chk("R2 address slice", fl_ad_o, pad[k*8 +: 8]);
        @(negedge clk);
      end
      for (int i = 0; i < n; i++) begin
        for (int c = 0; c <= acc; c++) begin
          chk(mid ? "R11 access window (cfg changed)" : "R3 access window",
              stat(), 8'b0000_0000);
          chk("R4 low address", fl_lo_addr, {a[2], 2'(first + i)});
          @(negedge clk);
        end
        for (int r = 0; r < rec; r++) begin
          chk(mid ? "R11 recovery (cfg changed)" : "R6 recovery gap",
              stat(), 8'b0110_0000);
          @(negedge clk);
        end
      end
      chk("R5 R8 response status", stat(), 8'b0110_0001);
      chk("R7 packed data", {rsp_err, rsp_data}, {1'b0, exp_d});
    end
    @(negedge clk);
    chk("R8 ready after response", stat(), 8'b1110_0000);
    cfg_acc = 4'(acc);
    cfg_rec = 4'(rec);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", stat(), 8'b1110_0000);
    // every byte-enable pattern, R5 R7 R9 R10
    for (int b = 0; b < 16; b++)
      do_req(23'h2B_4C91 ^ 23'(b << 9), 4'(b), 2, 1, 2, 0);
    do_req(23'h7F_FFFC, 4'hF, 0, 0, 0, 0);   // R3 R6 zero delays
    do_req(23'h01_2345, 4'h3, 15, 15, 10, 0); // R3 R6 maximum delays
    do_req(23'h55_AAA8, 4'hE, 3, 0, 3, 0);    // R6 back-to-back
    do_req(23'h13_5797, 4'h6, 2, 2, 2, 1);    // R11 mid-request change
    do_req(23'h00_0004, 4'hC, 1, 3, 1, 0);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule